// File: doc/BRIEF.md
# Bus-to-Device Four-Phase Handshake Bridge

This block joins two return-to-zero handshakes. On the bus side, a read request strobe or a write request strobe arrives, and the block answers with a bus acknowledge. On the device side, the block drives a local request strobe and a data transceiver enable, and it receives a local acknowledge. The block runs each cycle in a fixed order. It makes both sides return to zero before it accepts another cycle. It raises a one-cycle fault pulse when an input moves out of order.

All inputs are synchronous to `clk` and are already free of glitches. The controller is a registered state machine. Several of its states have the same values on all ports, for example idle and the two return-to-zero waits. The state register keeps these states apart, so the same port values can lead to different next outputs. Every output is a flop that loads the decode of the next state. An output therefore moves on the same clock edge that samples its enabling input.

Top module: `hs_bridge`

## Requirements
- R1: While `rst_n` is low at a clock edge, all four outputs are 0 after that edge, whatever the inputs are.
- R2: Read, with `dev_ack` low: the edge that samples `rd_req` high sets `dev_req`. The edge that samples `dev_ack` high sets `xcvr_en`. The next edge sets `bus_ack`.
- R3: Read release: the edge that samples `rd_req` low clears `xcvr_en`. The next edge clears `bus_ack` and `dev_req` together. The controller returns to idle on the edge that samples `dev_ack` low. From idle it can accept a new request.
- R4: Write: the edge that samples `wr_req` high sets `xcvr_en`. The next edge sets `dev_req`. The edge that samples `dev_ack` high clears `xcvr_en`. The next edge sets `bus_ack`.
- R5: Write release: the edge that samples `wr_req` low clears `bus_ack` and `dev_req` together. The controller returns to idle on the edge that samples `dev_ack` low.
- R6: If `rd_req` and `wr_req` are both high in idle, no cycle starts and the request is treated as a fault.
- R7: A read request that arrives while `dev_ack` from the previous cycle is still high is held off. `dev_req` rises only on the edge after the controller has seen `dev_ack` low and returned to idle.
- R8: A transition taken on a sampled input always completes, even if that input reverses in the next cycle. For example, `xcvr_en` falls after `rd_req` is sampled low, even if `rd_req` rises again one cycle later. That re-rise is then reported as a fault.
- R9: Any of the following is a fault: a strobe falling before `bus_ack` is high, the other strobe rising during a cycle, `dev_ack` rising when it was not requested or falling before `dev_req` has dropped, or a strobe rising again before `bus_ack` has fallen. On the edge that samples a fault, `proto_err` goes high for exactly one cycle and all other outputs go low.
- R10: After a fault, the controller stays inert (all outputs low) until `rd_req`, `wr_req` and `dev_ack` are all sampled low. On that edge it returns to idle.
- R11: `dev_req` rises only when `dev_ack` was sampled low. `bus_ack` rises only while `dev_req` is high and `dev_ack` was sampled high.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| rd_req | input | 1 | Bus read request strobe |
| wr_req | input | 1 | Bus write request strobe |
| bus_ack | output | 1 | Bus data acknowledge |
| dev_req | output | 1 | Local strobe to the device |
| dev_ack | input | 1 | Local acknowledge from the device |
| xcvr_en | output | 1 | Data latch / transceiver enable |
| proto_err | output | 1 | One-cycle protocol violation pulse |

## Verification
Idle and the two return-to-zero waits can show the same port values. A state register holding the wrong value therefore stays hidden until the next input edge. It shows up within one clock as a missing or early `dev_req`: a read accepted while `dev_ack` is still high, or held back after `dev_ack` has fallen. It can also show up as a fault pulse that should not be there. The directed tests are built to reach those points. Each check samples the ports one edge after the input that decides the state.

// File: rtl/hs_bridge_pkg.sv
// Package: shared state type and output bundle for the handshake bridge.
// Assumes: nothing beyond IEEE 1800-2017 packages.
package hs_bridge_pkg;

    localparam int STATE_W = 4;

    typedef enum logic [STATE_W-1:0] {
        ST_IDLE    = 4'd0,
        ST_RD_REQ  = 4'd1,
        ST_RD_XEN  = 4'd2,
        ST_RD_ACK  = 4'd3,
        ST_RD_DROP = 4'd4,
        ST_RD_RTZ  = 4'd5,
        ST_WR_XEN  = 4'd6,
        ST_WR_REQ  = 4'd7,
        ST_WR_XOFF = 4'd8,
        ST_WR_ACK  = 4'd9,
        ST_WR_RTZ  = 4'd10,
        ST_FAULT   = 4'd11
    } hs_state_e;

    typedef struct packed {
        logic bus_ack;
        logic dev_req;
        logic xcvr_en;
    } hs_drive_t;

    // Output values that belong to each state.
    function automatic hs_drive_t drive_of(hs_state_e st);
        hs_drive_t d;
        d = '0;
        unique case (st)
            ST_RD_REQ:  d.dev_req = 1'b1;
            ST_RD_XEN:  begin d.dev_req = 1'b1; d.xcvr_en = 1'b1; end
            ST_RD_ACK:  begin d.dev_req = 1'b1; d.xcvr_en = 1'b1; d.bus_ack = 1'b1; end
            ST_RD_DROP: begin d.dev_req = 1'b1; d.bus_ack = 1'b1; end
            ST_WR_XEN:  d.xcvr_en = 1'b1;
            ST_WR_REQ:  begin d.xcvr_en = 1'b1; d.dev_req = 1'b1; end
            ST_WR_XOFF: d.dev_req = 1'b1;
            ST_WR_ACK:  begin d.dev_req = 1'b1; d.bus_ack = 1'b1; end
            default:    d = '0;
        endcase
        return d;
    endfunction

endpackage

// File: rtl/hs_bridge_guard.sv
// Module: hs_bridge_guard
// Purpose: for the current state, flags any input value that breaks the
// expected handshake order (alternation, exclusive strobes, unrequested ack).
// Assumes: inputs are synchronous and glitch-free; purely combinational.
module hs_bridge_guard
    import hs_bridge_pkg::*;
(
    input  hs_state_e state_q,
    input  logic      rd_req,
    input  logic      wr_req,
    input  logic      dev_ack,
    output logic      viol
);

    // Per-state list of input values that are out of sequence.
    always_comb begin
        viol = 1'b0;
        unique case (state_q)
            ST_IDLE:    viol = (rd_req & wr_req) | dev_ack;
            ST_RD_REQ:  viol = ~rd_req | wr_req;
            ST_RD_XEN:  viol = ~rd_req | wr_req | ~dev_ack;
            ST_RD_ACK:  viol = wr_req | ~dev_ack;
            ST_RD_DROP: viol = rd_req | wr_req | ~dev_ack;
            ST_WR_XEN:  viol = ~wr_req | rd_req | dev_ack;
            ST_WR_REQ:  viol = ~wr_req | rd_req;
            ST_WR_XOFF: viol = ~wr_req | rd_req | ~dev_ack;
            ST_WR_ACK:  viol = rd_req | ~dev_ack;
            default:    viol = 1'b0;
        endcase
    end

endmodule

// File: rtl/hs_bridge_seq.sv
// Module: hs_bridge_seq
// Purpose: holds the controller state and computes the next state from the
// sampled inputs; a guard violation always wins and leads to ST_FAULT.
// Assumes: synchronous active-low reset; viol comes from hs_bridge_guard.
module hs_bridge_seq
    import hs_bridge_pkg::*;
(
    input  logic      clk,
    input  logic      rst_n,
    input  logic      rd_req,
    input  logic      wr_req,
    input  logic      dev_ack,
    input  logic      viol,
    output hs_state_e state_q,
    output hs_state_e state_d
);

    // Next-state selection for the read and write sequences.
    always_comb begin
        state_d = state_q;
        if (viol) begin
            state_d = ST_FAULT;
        end else begin
            unique case (state_q)
                ST_IDLE: begin
                    if (rd_req && !dev_ack)      state_d = ST_RD_REQ;
                    else if (wr_req && !dev_ack) state_d = ST_WR_XEN;
                end
                ST_RD_REQ:  if (dev_ack) state_d = ST_RD_XEN;
                ST_RD_XEN:  state_d = ST_RD_ACK;
                ST_RD_ACK:  if (!rd_req) state_d = ST_RD_DROP;
                ST_RD_DROP: state_d = ST_RD_RTZ;
                ST_RD_RTZ:  if (!dev_ack) state_d = ST_IDLE;
                ST_WR_XEN:  state_d = ST_WR_REQ;
                ST_WR_REQ:  if (dev_ack) state_d = ST_WR_XOFF;
                ST_WR_XOFF: state_d = ST_WR_ACK;
                ST_WR_ACK:  if (!wr_req) state_d = ST_WR_RTZ;
                ST_WR_RTZ:  if (!dev_ack) state_d = ST_IDLE;
                ST_FAULT:   if (!rd_req && !wr_req && !dev_ack) state_d = ST_IDLE;
                default:    state_d = ST_FAULT;
            endcase
        end
    end

    // State register with synchronous reset to idle.
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // R8
    rd_release_persist_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_RD_ACK && !rd_req && !viol) |=> (state_q == ST_RD_DROP));

    // R10
    fault_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_FAULT && (rd_req || wr_req || dev_ack)) |=> (state_q == ST_FAULT));

    // R7
    rtz_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_RD_RTZ && dev_ack) |=> (state_q == ST_RD_RTZ || state_q == ST_FAULT));

endmodule

// File: rtl/hs_bridge_drive.sv
// Module: hs_bridge_drive
// Purpose: registers the outputs from the next state so that each output
// moves on the edge that samples its enabling input; flags faults for one cycle.
// Assumes: synchronous active-low reset; state_d and viol are combinational.
module hs_bridge_drive
    import hs_bridge_pkg::*;
(
    input  logic      clk,
    input  logic      rst_n,
    input  hs_state_e state_d,
    input  logic      viol,
    input  logic      dev_ack,
    output logic      bus_ack_q,
    output logic      dev_req_q,
    output logic      xcvr_en_q,
    output logic      err_q
);

    hs_drive_t nxt;

    // Output values that go with the next state.
    always_comb nxt = drive_of(state_d);

    // Output flops, cleared by reset.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            bus_ack_q <= 1'b0;
            dev_req_q <= 1'b0;
            xcvr_en_q <= 1'b0;
            err_q     <= 1'b0;
        end else begin
            bus_ack_q <= nxt.bus_ack;
            dev_req_q <= nxt.dev_req;
            xcvr_en_q <= nxt.xcvr_en;
            err_q     <= viol;
        end
    end

    // R9
    err_single_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        err_q |=> !err_q);

    // R11
    dev_req_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(dev_req_q) |-> !$past(dev_ack));

    // R11
    bus_ack_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(bus_ack_q) |-> (dev_req_q && $past(dev_ack)));

    // R3
    release_pair_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(bus_ack_q) |-> !dev_req_q);

    // R2
    xen_entry_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(xcvr_en_q) |-> (dev_req_q == $past(dev_ack)));

endmodule

// File: rtl/hs_bridge.sv
// Module: hs_bridge (top)
// Purpose: clocked bridge between a bus four-phase handshake (read or write
// strobe in, acknowledge out) and a device four-phase handshake (strobe out,
// acknowledge in, transceiver enable out), with a protocol fault pulse.
// Assumes: all inputs synchronous to clk and glitch-free; reset synchronous.
module hs_bridge
    import hs_bridge_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic rd_req,
    input  logic wr_req,
    output logic bus_ack,
    output logic dev_req,
    input  logic dev_ack,
    output logic xcvr_en,
    output logic proto_err
);

    hs_state_e state_q;
    hs_state_e state_d;
    logic      viol;

    hs_bridge_guard guard_i (
        .state_q (state_q),
        .rd_req  (rd_req),
        .wr_req  (wr_req),
        .dev_ack (dev_ack),
        .viol    (viol)
    );

    hs_bridge_seq seq_i (
        .clk     (clk),
        .rst_n   (rst_n),
        .rd_req  (rd_req),
        .wr_req  (wr_req),
        .dev_ack (dev_ack),
        .viol    (viol),
        .state_q (state_q),
        .state_d (state_d)
    );

    hs_bridge_drive drive_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .state_d   (state_d),
        .viol      (viol),
        .dev_ack   (dev_ack),
        .bus_ack_q (bus_ack),
        .dev_req_q (dev_req),
        .xcvr_en_q (xcvr_en),
        .err_q     (proto_err)
    );

    // R6
    dual_strobe_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_IDLE && rd_req && wr_req) |=> (proto_err && !dev_req && !xcvr_en));

endmodule

// File: tb/hs_bridge_tb.sv
`timescale 1ns/1ps
// Directed bench for hs_bridge: one task per scenario, each checking itself.
module hs_bridge_tb_top;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic rd_req = 1'b0;
    logic wr_req = 1'b0;
    logic dev_ack = 1'b0;
    logic bus_ack, dev_req, xcvr_en, proto_err;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #4 clk = ~clk;

    hs_bridge dut_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .rd_req    (rd_req),
        .wr_req    (wr_req),
        .bus_ack   (bus_ack),
        .dev_req   (dev_req),
        .dev_ack   (dev_ack),
        .xcvr_en   (xcvr_en),
        .proto_err (proto_err)
    );

    // Advance to the next falling edge (one rising edge has passed).
    task automatic tick();
        @(negedge clk);
    endtask

    // Compare {bus_ack, dev_req, xcvr_en, proto_err} with the expected value.
    task automatic chk(input string req, input logic [3:0] exp);
        logic [3:0] act;
        act = {bus_ack, dev_req, xcvr_en, proto_err};
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: outputs {bus_ack,dev_req,xcvr_en,proto_err} = %b, expected %b at %0t",
                     req, act, exp, $time);
        end
    endtask

    task automatic do_reset();
        rst_n = 1'b0; rd_req = 1'b0; wr_req = 1'b0; dev_ack = 1'b0;
        tick(); tick();
        rst_n = 1'b1;
    endtask

    // R1: reset clears outputs even with inputs active.
    task automatic t_reset();
        do_reset();
        rd_req = 1'b1; tick();
        rst_n = 1'b0; tick();
        chk("R1", 4'b0000);
        rd_req = 1'b0; wr_req = 1'b1; dev_ack = 1'b1; tick();
        chk("R1", 4'b0000);
    endtask

    // R2, R3: full read cycle and re-acceptance from idle.
    task automatic t_read();
        do_reset();
        rd_req = 1'b1; tick(); chk("R2", 4'b0100);
        tick(); chk("R2", 4'b0100);
        dev_ack = 1'b1; tick(); chk("R2", 4'b0110);
        tick(); chk("R2", 4'b1110);
        tick(); chk("R3", 4'b1110);
        rd_req = 1'b0; tick(); chk("R3", 4'b1100);
        tick(); chk("R3", 4'b0000);
        tick(); chk("R3", 4'b0000);
        dev_ack = 1'b0; tick(); chk("R3", 4'b0000);
        rd_req = 1'b1; tick(); chk("R3", 4'b0100);
    endtask

    // R4, R5: full write cycle and re-acceptance from idle.
    task automatic t_write();
        do_reset();
        wr_req = 1'b1; tick(); chk("R4", 4'b0010);
        tick(); chk("R4", 4'b0110);
        tick(); chk("R4", 4'b0110);
        dev_ack = 1'b1; tick(); chk("R4", 4'b0100);
        tick(); chk("R4", 4'b1100);
        wr_req = 1'b0; tick(); chk("R5", 4'b0000);
        tick(); chk("R5", 4'b0000);
        dev_ack = 1'b0; tick(); chk("R5", 4'b0000);
        wr_req = 1'b1; tick(); chk("R5", 4'b0010);
    endtask

    // R6, R9: both strobes from idle give a single fault pulse.
    task automatic t_dual();
        do_reset();
        rd_req = 1'b1; wr_req = 1'b1; tick(); chk("R6", 4'b0001);
        tick(); chk("R9", 4'b0000);
        rd_req = 1'b0; wr_req = 1'b0; tick(); chk("R6", 4'b0000);
        rd_req = 1'b1; tick(); chk("R6", 4'b0100);
    endtask

    // R7: read request held off until the previous ack has fallen.
    task automatic t_hold();
        do_reset();
        rd_req = 1'b1; tick();
        dev_ack = 1'b1; tick(); tick();
        rd_req = 1'b0; tick(); tick();
        chk("R7", 4'b0000);
        rd_req = 1'b1; tick(); chk("R7", 4'b0000);
        tick(); chk("R7", 4'b0000);
        dev_ack = 1'b0; tick(); chk("R7", 4'b0000);
        tick(); chk("R7", 4'b0100);
    endtask

    // R8: sampled release completes, later re-rise becomes a fault.
    task automatic t_persist();
        do_reset();
        rd_req = 1'b1; tick();
        dev_ack = 1'b1; tick(); tick();
        chk("R8", 4'b1110);
        rd_req = 1'b0; tick(); chk("R8", 4'b1100);
        rd_req = 1'b1; tick(); chk("R8", 4'b0001);
    endtask

    // R9: other strobe during read, early strobe drop in write.
    task automatic t_order();
        do_reset();
        rd_req = 1'b1; tick();
        dev_ack = 1'b1; tick(); chk("R9", 4'b0110);
        wr_req = 1'b1; tick(); chk("R9", 4'b0001);
        tick(); chk("R9", 4'b0000);
        do_reset();
        wr_req = 1'b1; tick(); tick(); chk("R9", 4'b0110);
        wr_req = 1'b0; tick(); chk("R9", 4'b0001);
    endtask

    // R10: recovery only once every input is low.
    task automatic t_recover();
        do_reset();
        dev_ack = 1'b1; tick(); chk("R10", 4'b0001);
        tick(); chk("R10", 4'b0000);
        rd_req = 1'b1; tick(); chk("R10", 4'b0000);
        dev_ack = 1'b0; tick(); chk("R10", 4'b0000);
        rd_req = 1'b0; tick(); chk("R10", 4'b0000);
        rd_req = 1'b1; tick(); chk("R10", 4'b0100);
    endtask

    // R11: dev_req waits for a low ack even when requested.
    task automatic t_ack_gate();
        do_reset();
        dev_ack = 1'b0; wr_req = 1'b1; tick(); tick();
        chk("R11", 4'b0110);
        dev_ack = 1'b1; tick(); tick();
        chk("R11", 4'b1100);
    endtask

    initial begin
        tick();
        t_reset();
        t_read();
        t_write();
        t_dual();
        t_hold();
        t_persist();
        t_order();
        t_recover();
        t_ack_gate();
        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    // Watchdog: a hung run counts as a failed check.
    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: run did not complete, actual hung, expected done");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

endmodule